// File: doc/BRIEF.md
# Percent-Duty PWM Register Peripheral

This peripheral drives one pulse-width-modulated output from a duty command written as a whole percentage. Software reaches two registers through a simple select/write register port. The first register holds a single output-enable bit. The second holds the duty command, which is clamped to the range 0..100. A step counter runs through a fixed 100-step period. The output is high while the step count is below the duty value that is active for the current period.

The output is gated in two ways: by the enable bit, and by an external peripheral clock-enable input. While that input is low, the counter is parked at step zero and the output stays low. A status output shows the clock-gated condition, so an observer can tell a stopped clock apart from a zero duty. An average-level output reports the duty in force while the output is live. Duty changes are deferred to the next period boundary, so a period never carries a truncated or doubled pulse.

Top module: `pctpwm_top`

## Requirements
- R1: After reset, both registers read 0, `pwm_out` is low and `avg_level` is 0.
- R2: Offset 0x00 is the enable register. Bit 0 is the output-enable bit. Bits 31:1 read as zero whatever was written.
- R3: Offset 0x04 is the duty register, with the duty in bits 6:0. A written value greater than 100 (taking all 32 bits of the write data) is stored as 100. Reads return the stored value, with bits 31:7 zero.
- R4: Reads of any other offset return 0. Writes to any other offset change neither register.
- R5: `pwm_out` is low unless the enable bit is 1 and `pclk_en` is 1. `clk_gated` equals the inverse of `pclk_en`.
- R6: While `pclk_en` is 1, the step counter advances by one each clock from 0 to 99 and then wraps to 0. `pwm_out` is high exactly while the step is less than the active duty. A duty of 0 keeps the output low, and a duty of 100 keeps it high, over every step.
- R7: The active duty is reloaded from the duty register only on the clock where the counter wraps from 99 to 0, or on any clock with `pclk_en` low. While `pclk_en` is low, the counter is held at 0.
- R8: `avg_level` equals the active duty while the enable bit and `pclk_en` are both 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_en | input | 1 | External peripheral clock enable |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pwm_out | output | 1 | PWM waveform |
| avg_level | output | 7 | Average level in percent while the output is live |
| clk_gated | output | 1 | High while the peripheral clock is off |

## Verification
The bench builds the block with its default parameters: 100 steps and a 4-bit offset. This keeps full periods short enough to count the high cycles of each period exactly for duties of 0, 37 and 100. Random writes, including values far above 100 and writes to unmapped offsets, are mixed with random clock-enable drops. These reach both reload paths: the wrap at step 99 and the gated state. A bench model of the step and active duty checks `pwm_out`, `avg_level` and `clk_gated` on every cycle.

// File: rtl/pctpwm_pkg.sv
package pctpwm_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned OFS_ENABLE = 32'h0;
    localparam int unsigned OFS_DUTY   = 32'h4;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_DUTY   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic       sel;
        logic       wr;
        reg_sel_e   target;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_offset(input logic [DATA_W-1:0] ofs);
        if (ofs == OFS_ENABLE) return SEL_ENABLE;
        if (ofs == OFS_DUTY)   return SEL_DUTY;
        return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] clamp_pct(input logic [DATA_W-1:0] v,
                                                   input int unsigned limit);
        logic [DATA_W-1:0] lim;
        lim = DATA_W'(limit);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/pctpwm_regs.sv
module pctpwm_regs
    import pctpwm_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned STEPS  = 100,
    localparam int unsigned DUTY_W = $clog2(STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en_bit,
    output logic [DUTY_W-1:0] duty_cmd
);

    bus_req_t          req;
    logic [DATA_W-1:0] clamped;

    always_comb begin
        req.sel    = bus_sel;
        req.wr     = bus_wr;
        req.target = decode_offset(DATA_W'(bus_addr));
        req.wdata  = bus_wdata;
        clamped    = clamp_pct(bus_wdata, STEPS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_bit   <= 1'b0;
            duty_cmd <= '0;
        end else if (req.sel && req.wr) begin
            case (req.target)
                SEL_ENABLE: en_bit   <= req.wdata[0];
                SEL_DUTY:   duty_cmd <= clamped[DUTY_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (req.sel) begin
            case (req.target)
                SEL_ENABLE: bus_rdata[0]        = en_bit;
                SEL_DUTY:   bus_rdata[DUTY_W-1:0] = duty_cmd;
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && DATA_W'(bus_addr) == OFS_ENABLE) |=> en_bit == $past(bus_wdata[0])); // R2

    AST_DUTY_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && DATA_W'(bus_addr) == OFS_DUTY && bus_wdata > DATA_W'(STEPS))
        |=> 32'(duty_cmd) == STEPS); // R3

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && DATA_W'(bus_addr) != OFS_ENABLE && DATA_W'(bus_addr) != OFS_DUTY)
        |=> ($stable(en_bit) && $stable(duty_cmd))); // R4

endmodule

// File: rtl/pctpwm_stepgen.sv
module pctpwm_stepgen #(
    parameter int unsigned STEPS = 100,
    localparam int unsigned DUTY_W = $clog2(STEPS + 1),
    localparam int unsigned CNT_W  = $clog2(STEPS),
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pclk_en,
    input  logic [DUTY_W-1:0] duty_cmd,
    output logic [CNT_W-1:0]  step,
    output logic [DUTY_W-1:0] active_duty
);

    logic wrap;
    assign wrap = (step == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            step        <= '0;
            active_duty <= '0;
        end else if (!pclk_en) begin
            step        <= '0;
            active_duty <= duty_cmd;
        end else if (wrap) begin
            step        <= '0;
            active_duty <= duty_cmd;
        end else begin
            step        <= step + CNT_W'(1);
        end
    end

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (pclk_en && step != LAST) |=> step == $past(step) + CNT_W'(1)); // R6

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pclk_en && step == LAST) |=> step == '0); // R6

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pclk_en && step != LAST) |=> $stable(active_duty)); // R7

    AST_PARKED: assert property (@(posedge clk) disable iff (rst)
        !pclk_en |=> (step == '0 && active_duty == $past(duty_cmd))); // R7

endmodule

// File: rtl/pctpwm_gate.sv
module pctpwm_gate #(
    parameter int unsigned STEPS = 100,
    localparam int unsigned DUTY_W = $clog2(STEPS + 1),
    localparam int unsigned CNT_W  = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_bit,
    input  logic              pclk_en,
    input  logic [CNT_W-1:0]  step,
    input  logic [DUTY_W-1:0] active_duty,
    output logic              pwm_out,
    output logic [DUTY_W-1:0] avg_level,
    output logic              clk_gated
);

    logic live;
    logic below;

    always_comb begin
        live      = en_bit && pclk_en;
        below     = 32'(step) < 32'(active_duty);
        pwm_out   = live && below;
        avg_level = live ? active_duty : '0;
        clk_gated = !pclk_en;
    end

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (rst)
        !(en_bit && pclk_en) |-> !pwm_out); // R5

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
        (en_bit && pclk_en && 32'(active_duty) == STEPS) |-> pwm_out); // R6

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        (active_duty == '0) |-> !pwm_out); // R6

    AST_AVG_OFF: assert property (@(posedge clk) disable iff (rst)
        !(en_bit && pclk_en) |-> avg_level == '0); // R8

endmodule

// File: rtl/pctpwm_top.sv
module pctpwm_top
    import pctpwm_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned STEPS  = 100,
    localparam int unsigned DUTY_W = $clog2(STEPS + 1),
    localparam int unsigned CNT_W  = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pclk_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out,
    output logic [DUTY_W-1:0] avg_level,
    output logic              clk_gated
);

    logic              en_bit;
    logic [DUTY_W-1:0] duty_cmd;
    logic [CNT_W-1:0]  step;
    logic [DUTY_W-1:0] active_duty;

    pctpwm_regs #(.ADDR_W(ADDR_W), .STEPS(STEPS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_bit    (en_bit),
        .duty_cmd  (duty_cmd)
    );

    pctpwm_stepgen #(.STEPS(STEPS)) u_step (
        .clk         (clk),
        .rst         (rst),
        .pclk_en     (pclk_en),
        .duty_cmd    (duty_cmd),
        .step        (step),
        .active_duty (active_duty)
    );

    pctpwm_gate #(.STEPS(STEPS)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .en_bit      (en_bit),
        .pclk_en     (pclk_en),
        .step        (step),
        .active_duty (active_duty),
        .pwm_out     (pwm_out),
        .avg_level   (avg_level),
        .clk_gated   (clk_gated)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pwm_out && avg_level == '0)); // R1

endmodule

// File: tb/pctpwm_top_tb.sv
module pctpwm_top_tb;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned STEPS  = 100;
    localparam int unsigned DUTY_W = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pclk_en = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              pwm_out;
    logic [DUTY_W-1:0] avg_level;
    logic              clk_gated;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference state
    logic        m_en = 1'b0;
    int unsigned m_duty = 0;
    int unsigned m_step = 0;
    int unsigned m_act = 0;

    always #2 clk = ~clk;

    pctpwm_top #(.ADDR_W(ADDR_W), .STEPS(STEPS)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pclk_en   (pclk_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .avg_level (avg_level),
        .clk_gated (clk_gated)
    );

    function automatic int unsigned exp_clamp(input logic [31:0] v);
        return (v > 32'd100) ? 100 : int'(v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en <= 1'b0; m_duty <= 0; m_step <= 0; m_act <= 0;
        end else begin
            if (bus_sel && bus_wr) begin
                if (bus_addr == 4'h0) m_en <= bus_wdata[0];
                else if (bus_addr == 4'h4) m_duty <= exp_clamp(bus_wdata);
            end
            if (!pclk_en) begin
                m_step <= 0; m_act <= m_duty;
            end else if (m_step == STEPS - 1) begin
                m_step <= 0; m_act <= m_duty;
            end else begin
                m_step <= m_step + 1;
            end
        end
    end

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: wait for the negedge, then compare outputs with the model
    task automatic cyc();
        bit live;
        @(negedge clk);
        live = m_en && pclk_en;
        check("R5/R6 pwm_out", pwm_out, (live && m_step < m_act) ? 1 : 0);
        check("R8 avg_level", avg_level, live ? m_act : 0);
        check("R5 clk_gated", clk_gated, pclk_en ? 0 : 1);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        cyc();
        check(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic count_period(input int unsigned exp, input string tag);
        int unsigned highs = 0;
        for (int i = 0; i < int'(STEPS); i++) begin
            cyc();
            if (pwm_out) highs++;
        end
        check(tag, highs, exp);
    endtask

    task automatic settle();
        for (int i = 0; i < int'(STEPS) + 5; i++) cyc();
    endtask

    initial begin
        int unsigned seed = 32'h00C0FFEE;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc();
        // R1 reset state
        check("R1 pwm_out after reset", pwm_out, 0);
        check("R1 avg_level after reset", avg_level, 0);
        rd(4'h0, 32'h0, "R1 enable reg reset");
        rd(4'h4, 32'h0, "R1 duty reg reset");

        // R2 reserved bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, 32'h1, "R2 enable reserved bits zero");
        wr(4'h0, 32'hFFFF_FFFE);
        rd(4'h0, 32'h0, "R2 enable bit cleared");

        // R3 clamping
        wr(4'h4, 32'd300);
        rd(4'h4, 32'd100, "R3 clamp 300");
        wr(4'h4, 32'h8000_0005);
        rd(4'h4, 32'd100, "R3 clamp high bits");
        wr(4'h4, 32'd101);
        rd(4'h4, 32'd100, "R3 clamp 101");
        wr(4'h4, 32'd100);
        rd(4'h4, 32'd100, "R3 exact 100");
        wr(4'h4, 32'd42);
        rd(4'h4, 32'd42, "R3 in range");

        // R4 unmapped offsets
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'h0);
        rd(4'h8, 32'h0, "R4 unmapped read");
        rd(4'h4, 32'd42, "R4 duty untouched");
        rd(4'h0, 32'h0, "R4 enable untouched");

        // R6 period content
        pclk_en = 1'b1;
        wr(4'h0, 32'h1);
        wr(4'h4, 32'd37);
        settle();
        count_period(37, "R6 duty 37 highs per period");
        wr(4'h4, 32'd0);
        settle();
        count_period(0, "R6 duty 0 highs per period");
        wr(4'h4, 32'd100);
        settle();
        count_period(100, "R6 duty 100 highs per period");

        // R5 gating by clock enable and by enable bit
        pclk_en = 1'b0;
        count_period(0, "R5 clock gated highs");
        pclk_en = 1'b1;
        wr(4'h0, 32'h0);
        count_period(0, "R5 enable off highs");
        wr(4'h0, 32'h1);

        // R7 deferred reload: change mid-period, model checks each cycle
        wr(4'h4, 32'd20);
        settle();
        for (int i = 0; i < 50; i++) cyc();
        wr(4'h4, 32'd80);
        for (int i = 0; i < 60; i++) cyc();
        check("R7 step position model sync", m_act, 80);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int unsigned op = $urandom_range(0, 19);
            if (op == 0) pclk_en = ~pclk_en;
            else if (op == 1) wr(4'h0, $urandom());
            else if (op == 2) wr(4'h4, ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(0, 110)));
            else if (op == 3) wr(4'($urandom_range(0, 15)), $urandom());
            else if (op == 4) rd(4'h4, 32'(m_duty), "R3 random read");
            else if (op == 5) rd(4'h0, {31'b0, m_en}, "R2 random read");
            else cyc();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule